// File: doc/BRIEF.md
# Path Parity and Remote Error Nibble Generator

This block sits in the transmit path of a high-order path overhead inserter and works on the bytes before they are scrambled. It XORs every byte of each path frame into an 8-bit even bit-interleaved parity word. At the next frame it writes that word into the parity overhead byte. It also fills the upper nibble of the path status byte with a remote error indication. That nibble comes from the error count reported by the local receive-side parity checker.

The upstream framer supplies the bytes with a valid flag and three markers: first byte of the frame, parity byte slot, and status byte slot. Firmware-level controls can do three things. They can replace the remote error count with a fixed 4-bit value. They can corrupt the parity byte of exactly one frame on each rising edge of an error-insert line. They can force the value 3 into the remote error nibble while that line and a global enable are both high. Every output byte appears one clock after its input byte.

Top module: `poh_b3_g1_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `out_vld` and `out_byte` become 0.
- R2: `out_vld` equals `in_vld` from one cycle earlier. A valid byte outside the parity and status slots leaves unchanged one cycle later.
- R3: The parity slot carries the XOR of all valid output bytes of the previous frame, including that frame's own parity and status bytes as sent. A frame begins at the valid byte with `in_sof` high. The first frame after reset covers the valid bytes seen since reset.
- R4: A rising edge of `err_ins` while `b3_err_en` is 1 inverts all 8 bits of the next parity byte. If the parity slot is in the same cycle, that byte is inverted. Two or more edges before that slot cause one inversion. Holding `err_ins` high causes no more inversions. Once armed, the inversion happens even if `b3_err_en` later drops.
- R5: A rising edge of `err_ins` while `b3_err_en` is 0 leaves every parity byte uncorrupted.
- R6: With no inhibit and no forcing, status bits 7:4 carry `rx_bip_cnt`, with values above 8 sent as 8.
- R7: With `rei_inhibit` at 1 and no forcing, status bits 7:4 carry `rei_sw_val`.
- R8: When `rei_force_en`, `err_ins` and `err_glob_en` are all 1, status bits 7:4 carry 3. This takes priority over the inhibit.
- R9: Status bits 3:0 pass through unchanged.
- R10: With `err_glob_en` at 0, `rei_force_en` has no effect on the status nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input byte valid |
| in_byte | input | 8 | Input path byte |
| in_sof | input | 1 | First byte of a path frame |
| in_b3_slot | input | 1 | Byte is the parity overhead position |
| in_g1_slot | input | 1 | Byte is the status overhead position |
| rx_bip_cnt | input | 4 | Receive-side parity error count |
| rei_inhibit | input | 1 | Use the fixed nibble instead of the count |
| rei_sw_val | input | 4 | Fixed remote error nibble |
| b3_err_en | input | 1 | Allow parity corruption |
| err_ins | input | 1 | Error-insert line (edge for parity, level for nibble) |
| rei_force_en | input | 1 | Enable forced remote error value |
| err_glob_en | input | 1 | Global error-insert enable |
| out_vld | output | 1 | Output byte valid |
| out_byte | output | 8 | Output path byte |

## Verification
The assertions assume that the parity and status slot markers are never both set on the same byte and are only raised together with `in_vld`. They also assume `in_vld` stays low while reset is held. The stimulus builds frames from a fixed layout with the markers at fixed positions, and it holds markers low on idle cycles. Idle gaps, the count value, the control bits and the error-insert pulses are random. Directed frames cover the clamp, held and repeated insert edges, disabled corruption and a globally gated force.

// File: rtl/poh_pkg.sv
package poh_pkg;
    localparam int BYTE_W     = 8;
    localparam int NIB_W      = 4;
    localparam int REI_MAX    = 8;
    localparam int REI_FORCED = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]  nib_t;

    typedef struct packed {
        logic  vld;
        logic  sof;
        logic  b3;
        logic  g1;
        byte_t data;
    } slot_t;

    typedef enum logic [1:0] {
        REI_FROM_CNT = 2'd0,
        REI_FROM_SW  = 2'd1,
        REI_FROM_ERR = 2'd2
    } rei_src_e;

    function automatic nib_t clamp_rei(input nib_t cnt);
        return (cnt > nib_t'(REI_MAX)) ? nib_t'(REI_MAX) : cnt;
    endfunction
endpackage

// File: rtl/poh_bip_acc.sv
module poh_bip_acc
    import poh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld,
    input  logic  sof,
    input  byte_t tx_byte,
    output byte_t prev_par
);
    byte_t acc_q;
    byte_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            held_q <= '0;
        end else if (vld) begin
            if (sof) begin
                held_q <= acc_q;
                acc_q  <= tx_byte;
            end else begin
                acc_q  <= acc_q ^ tx_byte;
            end
        end
    end

    // Parity of the finished frame is visible on the first byte of the next
    assign prev_par = (vld && sof) ? acc_q : held_q;
endmodule

// File: rtl/poh_err_arm.sv
module poh_err_arm (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic arm_en,
    input  logic b3_hit,
    output logic flip
);
    logic strobe_q;
    logic pend_q;
    logic rise;

    assign rise = strobe && !strobe_q;
    assign flip = pend_q || (rise && arm_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            strobe_q <= strobe;
            pend_q   <= b3_hit ? 1'b0 : flip;
        end
    end
endmodule

// File: rtl/poh_rei_sel.sv
module poh_rei_sel
    import poh_pkg::*;
(
    input  nib_t     rx_cnt,
    input  logic     inhibit,
    input  nib_t     sw_val,
    input  logic     force_en,
    input  logic     err_lvl,
    input  logic     glob_en,
    output nib_t     rei,
    output rei_src_e src
);
    always_comb begin
        if (force_en && err_lvl && glob_en) begin
            src = REI_FROM_ERR;
        end else if (inhibit) begin
            src = REI_FROM_SW;
        end else begin
            src = REI_FROM_CNT;
        end
    end

    always_comb begin
        case (src)
            REI_FROM_ERR: rei = nib_t'(REI_FORCED);
            REI_FROM_SW:  rei = sw_val;
            default:      rei = clamp_rei(rx_cnt);
        endcase
    end
endmodule

// File: rtl/poh_b3_g1_gen.sv
module poh_b3_g1_gen
    import poh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  logic [7:0] in_byte,
    input  logic       in_sof,
    input  logic       in_b3_slot,
    input  logic       in_g1_slot,
    input  logic [3:0] rx_bip_cnt,
    input  logic       rei_inhibit,
    input  logic [3:0] rei_sw_val,
    input  logic       b3_err_en,
    input  logic       err_ins,
    input  logic       rei_force_en,
    input  logic       err_glob_en,
    output logic       out_vld,
    output logic [7:0] out_byte
);
    slot_t    cur;
    byte_t    tx_byte;
    byte_t    prev_par;
    nib_t     rei_nib;
    rei_src_e rei_src;
    logic     b3_flip;

    assign cur = '{vld: in_vld, sof: in_sof, b3: in_b3_slot,
                   g1: in_g1_slot, data: in_byte};

    poh_err_arm u_arm (
        .clk    (clk),
        .rst    (rst),
        .strobe (err_ins),
        .arm_en (b3_err_en),
        .b3_hit (cur.vld && cur.b3),
        .flip   (b3_flip)
    );

    poh_rei_sel u_rei (
        .rx_cnt   (rx_bip_cnt),
        .inhibit  (rei_inhibit),
        .sw_val   (rei_sw_val),
        .force_en (rei_force_en),
        .err_lvl  (err_ins),
        .glob_en  (err_glob_en),
        .rei      (rei_nib),
        .src      (rei_src)
    );

    poh_bip_acc u_bip (
        .clk      (clk),
        .rst      (rst),
        .vld      (cur.vld),
        .sof      (cur.sof),
        .tx_byte  (tx_byte),
        .prev_par (prev_par)
    );

    always_comb begin
        tx_byte = cur.data;
        if (cur.b3) begin
            tx_byte = prev_par ^ {BYTE_W{b3_flip}};
        end else if (cur.g1) begin
            tx_byte = {rei_nib, cur.data[NIB_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_byte <= '0;
        end else begin
            out_vld  <= cur.vld;
            out_byte <= tx_byte;
        end
    end
endmodule

// File: rtl/poh_b3_g1_chk.sv
module poh_b3_g1_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_vld,
    input logic [7:0] in_byte,
    input logic       in_sof,
    input logic       in_b3_slot,
    input logic       in_g1_slot,
    input logic [3:0] rx_bip_cnt,
    input logic       rei_inhibit,
    input logic [3:0] rei_sw_val,
    input logic       b3_err_en,
    input logic       err_ins,
    input logic       rei_force_en,
    input logic       err_glob_en,
    input logic       out_vld,
    input logic [7:0] out_byte
);
    logic forced;
    assign forced = rei_force_en && err_ins && err_glob_en;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_vld && out_byte == 8'd0)); // R1

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_vld == $past(in_vld)); // R2

    AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_vld && !in_b3_slot && !in_g1_slot))
        |-> out_byte == $past(in_byte)); // R2

    AST_G1_LOW_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_vld && in_g1_slot && !in_b3_slot))
        |-> out_byte[3:0] == $past(in_byte[3:0])); // R9

    AST_REI_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_vld && in_g1_slot && !in_b3_slot
                              && !rei_inhibit && !forced))
        |-> out_byte[7:4] <= 4'd8); // R6

    AST_REI_SOFT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_vld && in_g1_slot && !in_b3_slot
                              && rei_inhibit && !forced))
        |-> out_byte[7:4] == $past(rei_sw_val)); // R7

    AST_REI_FORCE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_vld && in_g1_slot && !in_b3_slot && forced))
        |-> out_byte[7:4] == 4'd3); // R8
endmodule

bind poh_b3_g1_gen poh_b3_g1_chk chk_i (.*);

// File: tb/poh_b3_g1_gen_tb.sv
module poh_b3_g1_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FRM_LEN    = 16;
    localparam int B3_POS     = 2;
    localparam int G1_POS     = 4;
    localparam int WDOG_CYC   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_vld = 1'b0;
    logic [7:0] in_byte = 8'd0;
    logic       in_sof = 1'b0;
    logic       in_b3_slot = 1'b0;
    logic       in_g1_slot = 1'b0;
    logic [3:0] rx_bip_cnt = 4'd0;
    logic       rei_inhibit = 1'b0;
    logic [3:0] rei_sw_val = 4'd0;
    logic       b3_err_en = 1'b0;
    logic       err_ins = 1'b0;
    logic       rei_force_en = 1'b0;
    logic       err_glob_en = 1'b0;
    logic       out_vld;
    logic [7:0] out_byte;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state
    logic [7:0] m_acc = 8'd0;
    logic [7:0] m_held = 8'd0;
    logic       m_pend = 1'b0;
    logic       m_strq = 1'b0;
    string      tag_ovr = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    poh_b3_g1_gen dut_i (.*);

    function automatic logic [3:0] ref_rei();
        if (rei_force_en && err_ins && err_glob_en) return 4'd3;
        if (rei_inhibit) return rei_sw_val;
        return (rx_bip_cnt > 4'd8) ? 4'd8 : rx_bip_cnt;
    endfunction

    function automatic string g1_tag();
        if (rei_force_en && err_ins && err_glob_en) return "R8";
        if (rei_inhibit) return "R7";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic s, input logic b3,
                        input logic g1, input logic [7:0] d);
        logic       rise, flip;
        logic [7:0] prev, exp;
        string      tag;
        @(negedge clk);
        in_vld = v; in_sof = s; in_b3_slot = b3; in_g1_slot = g1; in_byte = d;
        rise = err_ins && !m_strq;
        flip = m_pend || (rise && b3_err_en);
        m_strq = err_ins;
        m_pend = (v && b3) ? 1'b0 : flip;
        prev = (v && s) ? m_acc : m_held;
        exp = d;
        tag = "R2";
        if (b3) begin
            exp = prev ^ {8{flip}};
            tag = flip ? "R4" : "R3";
        end else if (g1) begin
            exp = {ref_rei(), d[3:0]};
            tag = g1_tag();
        end
        if (tag_ovr != "") tag = tag_ovr;
        if (v) begin
            if (s) begin m_held = m_acc; m_acc = exp; end
            else m_acc = m_acc ^ exp;
        end
        @(posedge clk); #1;
        check("R2", {31'd0, out_vld}, {31'd0, v});
        if (v) begin
            check(tag, {24'd0, out_byte}, {24'd0, exp});
            if (g1) check("R9", {28'd0, out_byte[3:0]}, {28'd0, d[3:0]});
        end
    endtask

    task automatic frame(input int gap_pct, input int pulse_pct);
        for (int i = 0; i < FRM_LEN; i++) begin
            while (($urandom % 100) < gap_pct)
                step(1'b0, 1'b0, 1'b0, 1'b0, 8'($urandom));
            if (pulse_pct > 0) err_ins = (($urandom % 100) < pulse_pct);
            step(1'b1, i == 0, i == B3_POS, i == G1_POS, 8'($urandom));
        end
    endtask

    initial begin
        #(CLK_PERIOD * WDOG_CYC);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        #1;
        check("R1", {23'd0, out_vld, out_byte}, 32'd0);
        @(negedge clk); rst = 1'b0;

        // plain frames: parity chaining and count passthrough (R3, R6)
        for (int f = 0; f < 4; f++) begin
            rx_bip_cnt = 4'($urandom % 9);
            frame(20, 0);
        end

        // clamp of counts above 8 (R6)
        for (int c = 9; c < 16; c += 3) begin
            rx_bip_cnt = 4'(c);
            frame(0, 0);
        end

        // inhibit to fixed nibble (R7)
        rei_inhibit = 1'b1; rei_sw_val = 4'hA;
        frame(10, 0);
        rei_inhibit = 1'b0;

        // single edge corrupts one B3, held level does not repeat (R4)
        b3_err_en = 1'b1;
        err_ins = 1'b1;
        frame(0, 0);
        frame(0, 0);
        err_ins = 1'b0;
        // two edges before one B3 slot merge (R4)
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        err_ins = 1'b1; step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        err_ins = 1'b0; step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        err_ins = 1'b1; step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        err_ins = 1'b0; b3_err_en = 1'b0;
        frame(0, 0);
        frame(0, 0);

        // edge while corruption disabled (R5)
        tag_ovr = "R5";
        err_ins = 1'b1; step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        err_ins = 1'b0;
        frame(0, 0);
        tag_ovr = "";

        // force gated off by global enable (R10)
        tag_ovr = "R10";
        rei_force_en = 1'b1; err_glob_en = 1'b0; err_ins = 1'b1; rx_bip_cnt = 4'd5;
        frame(0, 0);
        tag_ovr = "";
        // force active, over inhibit (R8)
        err_glob_en = 1'b1; rei_inhibit = 1'b1;
        frame(0, 0);
        err_ins = 1'b0; rei_force_en = 1'b0; err_glob_en = 1'b0; rei_inhibit = 1'b0;

        // random mix
        for (int f = 0; f < 60; f++) begin
            rx_bip_cnt   = 4'($urandom);
            rei_inhibit  = ($urandom % 4) == 0;
            rei_sw_val   = 4'($urandom);
            b3_err_en    = $urandom % 2;
            rei_force_en = $urandom % 2;
            err_glob_en  = $urandom % 2;
            frame(25, 15);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule